// File: doc/BRIEF.md
# Segment Translation and Protection Unit

The unit turns a two-part logical address, a segment number and an offset inside that segment, into a physical address. It holds a small on-chip table of segment descriptors. Each descriptor carries a physical base, a segment limit, a valid flag and three access-permission bits. A separate register sets how many table slots are in use.

For each request the unit runs a fixed, ordered chain of legality checks. The first check that fails decides the trap cause. When every check passes, the output is the base plus the offset. The checks and the addition are combinational, and the result is registered, so a request made in one cycle is answered in the next.

Descriptors and the length register are loaded through a simple write port. A write lands at the clock edge. A request presented in the same cycle as a write is judged against the contents from before that write.

Top module: `seg_xlate_unit`

## Requirements
- R1: After synchronous reset, `xl_valid`, `xl_trap`, `xl_cause` and `xl_paddr` are all 0. Every descriptor is invalid and the length register is 0, so a request made before any load traps with cause 1.
- R2: A request with `rq_valid`=1 is answered one clock later with `xl_valid`=1. In a cycle with no request, the next cycle shows `xl_valid`=0, `xl_trap`=0, `xl_cause`=0 and `xl_paddr`=0.
- R3: A segment number is out of range when it is not less than the length register or not less than 8, the table size. Such a request traps with cause 1.
- R4: A request to an in-range segment whose descriptor has its valid flag at 0 traps with cause 2.
- R5: An offset that is not less than the descriptor's limit traps with cause 3. An offset of limit-1 is accepted.
- R6: The permission field has bit 0 for read, bit 1 for write and bit 2 for execute. The access code is 0 for read, 1 for write and 2 for execute. A request whose matching bit is 0 traps with cause 4. Access code 3 always traps with cause 4.
- R7: When several checks fail, the cause reported is the first one in this order: range (1), valid (2), limit (3), permission (4).
- R8: A request that passes every check gives `xl_trap`=0, `xl_cause`=0 and `xl_paddr` = (base + offset) mod 2^24. For example, base 4300 with offset 53 gives 4353. A trapped request gives `xl_paddr`=0.
- R9: A descriptor write with `tw_en`=1 takes effect at the clock edge. Requests in later cycles see the new descriptor. A request in the same cycle as the write sees the old one.
- R10: The length register loads `len_val` when `len_we`=1 and keeps its value otherwise. A new value applies from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_en | input | 1 | Descriptor write strobe |
| tw_idx | input | 3 | Descriptor slot to write |
| tw_base | input | 24 | Physical base to store |
| tw_limit | input | 16 | Segment limit to store |
| tw_valid | input | 1 | Valid flag to store |
| tw_perm | input | 3 | Permission bits to store (bit0 read, bit1 write, bit2 execute) |
| len_we | input | 1 | Length register write strobe |
| len_val | input | 4 | New length register value |
| rq_valid | input | 1 | Translation request strobe |
| rq_seg | input | 4 | Segment number |
| rq_off | input | 16 | Offset within the segment |
| rq_acc | input | 2 | Access code (0 read, 1 write, 2 execute, 3 reserved) |
| xl_valid | output | 1 | Registered result valid |
| xl_trap | output | 1 | Result is a trap |
| xl_cause | output | 3 | Trap cause, 0 when no trap |
| xl_paddr | output | 24 | Physical address, 0 on trap |

## Verification
The hardest situations to reach from the ports are requests where more than one check fails at once, such as an invalid descriptor with an offset past its limit and no permissions. Random descriptors seldom line up that way, so directed steps load slots built to fail two or three checks together and confirm that the earliest cause wins. Random requests then place offsets at limit-1, at the limit and just above it. Descriptor and length writes are mixed into the same cycles as requests, which exercises the old-contents rule for same-cycle writes.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int NSEG   = 8;
    localparam int IDX_W  = $clog2(NSEG);
    localparam int SEG_W  = IDX_W + 1;
    localparam int OFF_W  = 16;
    localparam int LIM_W  = 16;
    localparam int BASE_W = 24;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        TC_NONE  = 3'd0,
        TC_RANGE = 3'd1,
        TC_INVAL = 3'd2,
        TC_LIMIT = 3'd3,
        TC_PERM  = 3'd4
    } cause_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              valid;
        logic [2:0]        perm;
    } seg_desc_t;

    function automatic logic perm_allows(input logic [2:0] perm, input acc_e acc);
        case (acc)
            ACC_RD:  return perm[0];
            ACC_WR:  return perm[1];
            ACC_EX:  return perm[2];
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/segx_table.sv
module segx_table
    import segx_pkg::*;
#(
    parameter int ENTRIES = NSEG,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  seg_desc_t       wr_desc,
    input  logic [AW-1:0]   rd_idx,
    output seg_desc_t       rd_desc
);
    seg_desc_t slot_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == AW'(g))) begin
                slot_q[g] <= wr_desc;
            end
        end
    end

    assign rd_desc = slot_q[rd_idx];

    // R9: a written descriptor is held in its slot after the edge
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot_q[$past(wr_idx)] == $past(wr_desc));
endmodule

// File: rtl/segx_check.sv
module segx_check
    import segx_pkg::*;
(
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  acc_e              acc,
    input  logic [SEG_W-1:0]  len,
    input  seg_desc_t         desc,
    output cause_e            cause,
    output logic [BASE_W-1:0] paddr
);
    localparam logic [SEG_W-1:0] SEG_TOP = SEG_W'(NSEG);

    logic range_bad, inval_bad, limit_bad, perm_bad;

    always_comb begin
        range_bad = (seg >= len) || (seg >= SEG_TOP);
        inval_bad = !desc.valid;
        limit_bad = (LIM_W'(off) >= desc.limit);
        perm_bad  = !perm_allows(desc.perm, acc);

        if (range_bad)      cause = TC_RANGE;
        else if (inval_bad) cause = TC_INVAL;
        else if (limit_bad) cause = TC_LIMIT;
        else if (perm_bad)  cause = TC_PERM;
        else                cause = TC_NONE;

        paddr = (cause == TC_NONE) ? (desc.base + BASE_W'(off)) : '0;
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import segx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tw_en,
    input  logic [IDX_W-1:0]  tw_idx,
    input  logic [BASE_W-1:0] tw_base,
    input  logic [LIM_W-1:0]  tw_limit,
    input  logic              tw_valid,
    input  logic [2:0]        tw_perm,
    input  logic              len_we,
    input  logic [SEG_W-1:0]  len_val,
    input  logic              rq_valid,
    input  logic [SEG_W-1:0]  rq_seg,
    input  logic [OFF_W-1:0]  rq_off,
    input  logic [1:0]        rq_acc,
    output logic              xl_valid,
    output logic              xl_trap,
    output logic [2:0]        xl_cause,
    output logic [BASE_W-1:0] xl_paddr
);
    localparam logic [SEG_W-1:0] SEG_TOP = SEG_W'(NSEG);

    logic [SEG_W-1:0]  len_q;
    seg_desc_t         wr_d, rd_d;
    cause_e            chk_cause;
    logic [BASE_W-1:0] chk_paddr;

    assign wr_d = '{base: tw_base, limit: tw_limit, valid: tw_valid, perm: tw_perm};

    segx_table #(.ENTRIES(NSEG)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tw_en),
        .wr_idx  (tw_idx),
        .wr_desc (wr_d),
        .rd_idx  (rq_seg[IDX_W-1:0]),
        .rd_desc (rd_d)
    );

    segx_check u_check (
        .seg   (rq_seg),
        .off   (rq_off),
        .acc   (acc_e'(rq_acc)),
        .len   (len_q),
        .desc  (rd_d),
        .cause (chk_cause),
        .paddr (chk_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst)         len_q <= '0;
        else if (len_we) len_q <= len_val;
    end

    always_ff @(posedge clk) begin
        if (rst || !rq_valid) begin
            xl_valid <= 1'b0;
            xl_trap  <= 1'b0;
            xl_cause <= '0;
            xl_paddr <= '0;
        end else begin
            xl_valid <= 1'b1;
            xl_trap  <= (chk_cause != TC_NONE);
            xl_cause <= chk_cause;
            xl_paddr <= chk_paddr;
        end
    end

    // R2: each request is answered exactly one cycle later
    p_answer_r2: assert property (@(posedge clk) disable iff (rst)
        rq_valid |=> xl_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !rq_valid |=> (!xl_valid && xl_cause == 3'd0));
    // R3: out-of-range segment numbers trap with cause 1
    p_range_r3: assert property (@(posedge clk) disable iff (rst)
        (rq_valid && (rq_seg >= len_q || rq_seg >= SEG_TOP)) |=> (xl_trap && xl_cause == 3'd1));
    // R10: length register holds without a write
    p_len_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !len_we |=> $stable(len_q));
    // R8: a trap never carries an address
    p_trap_zero_r8: assert property (@(posedge clk) disable iff (rst)
        xl_trap |-> (xl_paddr == '0 && xl_valid));
endmodule

// File: tb/tb_seg_xlate_unit.sv
`timescale 1ns/1ps
module tb_seg_xlate_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        tw_en;
    logic [2:0]  tw_idx;
    logic [23:0] tw_base;
    logic [15:0] tw_limit;
    logic        tw_valid;
    logic [2:0]  tw_perm;
    logic        len_we;
    logic [3:0]  len_val;
    logic        rq_valid;
    logic [3:0]  rq_seg;
    logic [15:0] rq_off;
    logic [1:0]  rq_acc;
    logic        xl_valid, xl_trap;
    logic [2:0]  xl_cause;
    logic [23:0] xl_paddr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [23:0] m_base  [8];
    logic [15:0] m_limit [8];
    logic        m_valid [8];
    logic [2:0]  m_perm  [8];
    logic [3:0]  m_len;

    always #5 clk = ~clk;

    seg_xlate_unit dut (.*);

    function automatic void model_eval(input int seg, input int off, input int acc,
                                       output int cause, output logic [23:0] pa);
        int s;
        bit ok;
        s = seg & 7;
        pa = '0;
        if (seg >= int'(m_len) || seg >= 8) cause = 1;
        else if (!m_valid[s]) cause = 2;
        else if (off >= int'(m_limit[s])) cause = 3;
        else begin
            ok = (acc == 0) ? m_perm[s][0] : (acc == 1) ? m_perm[s][1] :
                 (acc == 2) ? m_perm[s][2] : 1'b0;
            if (!ok) cause = 4;
            else begin
                cause = 0;
                pa = m_base[s] + 24'(off);
            end
        end
    endfunction

    task automatic check(input string tag, input logic [28:0] act, input logic [28:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got valid/trap/cause/pa=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input int widx, input logic [23:0] wb, input logic [15:0] wl,
                        input bit wv, input logic [2:0] wp, input bit lwe, input int lv,
                        input bit rq, input int seg, input int off, input int acc, input string tag);
        int ec;
        logic [23:0] ep;
        @(negedge clk);
        tw_en = we; tw_idx = 3'(widx); tw_base = wb; tw_limit = wl; tw_valid = wv; tw_perm = wp;
        len_we = lwe; len_val = 4'(lv);
        rq_valid = rq; rq_seg = 4'(seg); rq_off = 16'(off); rq_acc = 2'(acc);
        model_eval(seg, off, acc, ec, ep);
        @(posedge clk);
        #1;
        if (we) begin
            m_base[widx & 7] = wb; m_limit[widx & 7] = wl;
            m_valid[widx & 7] = wv; m_perm[widx & 7] = wp;
        end
        if (lwe) m_len = 4'(lv);
        if (rq) check(tag, {xl_valid, xl_trap, xl_cause, xl_paddr},
                      {1'b1, ec != 0, 3'(ec), ep});
        else    check(tag, {xl_valid, xl_trap, xl_cause, xl_paddr}, 29'd0);
    endtask

    task automatic load(input int idx, input logic [23:0] b, input logic [15:0] l,
                        input bit v, input logic [2:0] p);
        step(1, idx, b, l, v, p, 0, 0, 0, 0, 0, 0, "R9_load");
    endtask

    task automatic req(input int seg, input int off, input int acc, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, seg, off, acc, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 0; m_perm[i] = '0;
        end
        m_len = '0;
        rst = 1; tw_en = 0; tw_idx = 0; tw_base = 0; tw_limit = 0; tw_valid = 0; tw_perm = 0;
        len_we = 0; len_val = 0; rq_valid = 0; rq_seg = 0; rq_off = 0; rq_acc = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1_reset", {xl_valid, xl_trap, xl_cause, xl_paddr}, 29'd0);
        @(negedge clk);
        rst = 0;

        req(0, 0, 0, "R1_empty_table");
        // same-cycle write and length load: old contents apply (R9, R10)
        step(1, 0, 24'd4300, 16'd100, 1, 3'b001, 1, 3, 1, 0, 53, 0, "R10_same_cycle");
        req(0, 53, 0, "R8_example_4353");
        req(0, 99, 0, "R5_limit_minus_one");
        req(0, 100, 0, "R5_at_limit");
        req(0, 101, 0, "R5_over_limit");
        req(0, 10, 1, "R6_write_denied");
        req(0, 10, 2, "R6_exec_denied");
        req(0, 10, 3, "R6_code3");
        req(3, 0, 0, "R3_seg_eq_len");
        req(2, 0, 0, "R4_invalid_slot");
        load(1, 24'd5000, 16'd0, 0, 3'b000);
        req(1, 500, 1, "R7_invalid_over_limit");
        load(2, 24'd6000, 16'd10, 1, 3'b000);
        req(2, 20, 1, "R7_limit_over_perm");
        req(2, 5, 1, "R7_perm_only");
        // same-cycle rewrite of slot 0: old limit 100 still applies
        step(1, 0, 24'hFFFFF0, 16'd200, 1, 3'b110, 0, 0, 1, 0, 150, 0, "R9_old_desc");
        req(0, 32, 2, "R8_wrap");
        req(0, 32, 0, "R9_new_perm");
        step(0, 0, 0, 0, 0, 0, 1, 9, 0, 0, 0, 0, "R2_idle");
        req(8, 0, 0, "R3_seg_past_table");
        req(7, 0, 0, "R4_slot7");

        for (int i = 0; i < 600; i++) begin
            bit we, lwe, rq;
            int seg, off, acc, sel, s;
            we  = ($urandom % 4) == 0;
            lwe = ($urandom % 10) == 0;
            rq  = ($urandom % 8) != 0;
            seg = $urandom % 10;
            s   = seg & 7;
            acc = $urandom % 4;
            sel = $urandom % 4;
            if (sel == 0)      off = int'(m_limit[s]) - 1;
            else if (sel == 1) off = int'(m_limit[s]);
            else if (sel == 2) off = int'(m_limit[s]) + 1;
            else               off = $urandom % 65536;
            if (off < 0) off = 0;
            if (off > 65535) off = 65535;
            step(we, $urandom % 8, 24'($urandom), 16'($urandom % 2000),
                 ($urandom % 4) != 0, 3'($urandom), lwe, $urandom % 10,
                 rq, seg, off, acc, "R7_random");
        end

        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1;
        check("R1_reset_again", {xl_valid, xl_trap, xl_cause, xl_paddr}, 29'd0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule